// File: doc/BRIEF.md
# Blanked PWM Pulse Generator

This block produces fixed-frequency gate pulses for a switching power stage from a free-running digital sawtooth. Each period starts with a dead-time stretch during which both outputs are held low. The pulse rises on the first clock after the dead time. It falls at whichever comes first: the counter reaching the duty word, a cycle-by-cycle current-limit flag, or an overcurrent flag. After it falls it stays low for the rest of the period.

A leading-edge blanking window, counted in clocks from the pulse start, hides the duty comparison and the current-limit flag. This lets switching noise at turn-on pass without cutting the pulse short. The overcurrent flag is never hidden. A mode input selects one of two output schemes. In the first, both outputs carry the same pulse every period. In the second, a toggle sends successive periods to output A and output B in turn. The analog comparators and the error amplifier sit outside the block, and their results arrive as synchronous flags.

Period, dead time and blanking length are sampled into the block at every period boundary. The duty word and the flags act live.

Top module: `bpwm_gen`

## Requirements
- R1: While `rst_n` is low, both outputs are low. After release, the period restarts at slot 0. The first period goes to output A in alternating mode.
- R2: A period lasts P slots, where P is `period_i` clamped to at least 2. The first D slots of each period are dead time with both outputs low, where D is `dead_i` clamped into 1..P-1. The on window therefore has L = P-D slots.
- R3: The pulse is high from the first on-window slot for `duty_i` slots, capped at L. The outputs are registered, so each slot appears at the outputs one clock later.
- R4: A duty word of 0 gives no pulse at all in that period.
- R5: For the first B slots of the on window, the duty comparison and the current-limit flag are ignored. B is `blank_i` clamped to at most L-1. A nonzero duty below B therefore gives a pulse B slots wide.
- R6: Outside blanking, `ilim_i` high in on-window slot k ends the pulse, giving a width of k.
- R7: `ocur_i` high in on-window slot k ends the pulse at once, giving a width of k, even inside the blanking window.
- R8: Once the pulse has ended, it stays low until the next period, even if the terminating flag drops.
- R9: With `alt_mode_i` = 0, both outputs carry the identical pulse every period.
- R10: With `alt_mode_i` = 1, the pulse goes to output A on even periods since reset and to output B on odd ones. The two outputs are never high together.
- R11: A change to period, dead time or blanking made during a period takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| period_i | input | CNT_W | Period length in clocks |
| dead_i | input | CNT_W | Dead-time length in clocks |
| blank_i | input | CNT_W | Blanking length in clocks |
| duty_i | input | CNT_W | Duty word, in on-window clocks |
| ilim_i | input | 1 | Current-limit flag (blankable) |
| ocur_i | input | 1 | Overcurrent flag (never blanked) |
| alt_mode_i | input | 1 | 0 = in-phase outputs, 1 = alternating |
| out_a_o | output | 1 | Gate pulse A |
| out_b_o | output | 1 | Gate pulse B |

## Verification
The following properties are checked on every clock by assertions:
- both outputs stay low after a dead-time slot, a zero duty word or an overcurrent flag;
- the outputs match in in-phase mode;
- the outputs never overlap in alternating mode;
- a pulse, once dropped, does not come back within the same period.

Other behaviours need the bench's scenarios, because they depend on how positions add up across a whole period:
- exact pulse widths under blanking and under the clamps;
- whether a flag inside the blanking window is masked;
- which output each period is steered to;
- the one-period delay before a new configuration takes effect.

// File: rtl/bpwm_pkg.sv
`timescale 1ns/1ps
package bpwm_pkg;

   typedef enum logic {
      PH_A = 1'b0,
      PH_B = 1'b1
   } phase_e;

   localparam int NUM_OUT = 2;

   // channel enable: in-phase drives all, alternating picks by parity
   function automatic logic chan_en(input int idx, input logic alt, input phase_e ph);
      if (!alt) return 1'b1;
      return ((idx % 2) == 0) ? (ph == PH_A) : (ph == PH_B);
   endfunction

endpackage

// File: rtl/bpwm_timebase.sv
`timescale 1ns/1ps
module bpwm_timebase #(
   parameter int CNT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CNT_W-1:0]    per_i,
   input  logic [CNT_W-1:0]    dead_i,
   input  logic [CNT_W-1:0]    blank_i,
   output logic [CNT_W-1:0]    cnt_o,
   output logic [CNT_W-1:0]    dead_o,
   output logic [CNT_W-1:0]    blank_o,
   output logic [CNT_W-1:0]    pos_o,
   output logic                on_win_o,
   output logic                last_o,
   output bpwm_pkg::phase_e    phase_o
);
   import bpwm_pkg::*;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   if (CNT_W < 2) begin : g_bad_width
      $error("bpwm_timebase: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] per_eff, dead_eff, on_len, blank_eff;
   logic [CNT_W-1:0] per_q, dead_q, blank_q, cnt_q;
   phase_e           phase_q;

   // clamp the incoming configuration into a legal set
   always_comb begin
      per_eff = (per_i < TWO) ? TWO : per_i;
      if (dead_i == '0)          dead_eff = ONE;
      else if (dead_i >= per_eff) dead_eff = per_eff - ONE;
      else                        dead_eff = dead_i;
      on_len    = per_eff - dead_eff;
      blank_eff = (blank_i >= on_len) ? (on_len - ONE) : blank_i;
   end

   assign last_o   = (cnt_q == (per_q - ONE));
   assign on_win_o = (cnt_q >= dead_q);
   assign pos_o    = cnt_q - dead_q;
   assign cnt_o    = cnt_q;
   assign dead_o   = dead_q;
   assign blank_o  = blank_q;
   assign phase_o  = phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         per_q   <= per_eff;
         dead_q  <= dead_eff;
         blank_q <= blank_eff;
         phase_q <= PH_A;
      end else if (last_o) begin
         cnt_q   <= '0;
         per_q   <= per_eff;
         dead_q  <= dead_eff;
         blank_q <= blank_eff;
         phase_q <= (phase_q == PH_A) ? PH_B : PH_A;
      end else begin
         cnt_q   <= cnt_q + ONE;
      end
   end

endmodule

// File: rtl/bpwm_term.sv
`timescale 1ns/1ps
module bpwm_term #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on_win_i,
   input  logic             last_i,
   input  logic [CNT_W-1:0] pos_i,
   input  logic [CNT_W-1:0] blank_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic             ilim_i,
   input  logic             ocur_i,
   output logic             drive_o
);
   logic alive_q;
   logic blanked, duty_hit, end_now;

   always_comb begin
      blanked  = (pos_i < blank_i);
      duty_hit = (pos_i >= duty_i);
      end_now  = ocur_i | (duty_i == '0) | (!blanked & (duty_hit | ilim_i));
      drive_o  = on_win_i & alive_q & !end_now;
   end

   // one pulse per period: armed at the boundary, disarmed on first end
   always_ff @(posedge clk) begin
      if (!rst_n)                   alive_q <= 1'b1;
      else if (last_i)              alive_q <= 1'b1;
      else if (on_win_i && end_now) alive_q <= 1'b0;
   end

endmodule

// File: rtl/bpwm_steer.sv
`timescale 1ns/1ps
module bpwm_steer #(
   parameter int NUM_OUT = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                drive_i,
   input  logic                alt_i,
   input  bpwm_pkg::phase_e    phase_i,
   output logic [NUM_OUT-1:0]  out_o
);
   import bpwm_pkg::*;

   if (NUM_OUT < 1) begin : g_bad_count
      $error("bpwm_steer: NUM_OUT must be at least 1");
   end

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_chan
      logic ch_q;
      always_ff @(posedge clk) begin
         if (!rst_n) ch_q <= 1'b0;
         else        ch_q <= drive_i & chan_en(i, alt_i, phase_i);
      end
      assign out_o[i] = ch_q;
   end

endmodule

// File: rtl/bpwm_gen.sv
`timescale 1ns/1ps
module bpwm_gen #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] dead_i,
   input  logic [CNT_W-1:0] blank_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic             ilim_i,
   input  logic             ocur_i,
   input  logic             alt_mode_i,
   output logic             out_a_o,
   output logic             out_b_o
);
   import bpwm_pkg::*;

   localparam int NOUT = bpwm_pkg::NUM_OUT;

   logic [CNT_W-1:0] cnt_w, dead_w, blank_w, pos_w;
   logic             on_win_w, last_w, drive_w;
   phase_e           phase_w;
   logic [NOUT-1:0]  outs_w;

   bpwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .per_i    (period_i),
      .dead_i   (dead_i),
      .blank_i  (blank_i),
      .cnt_o    (cnt_w),
      .dead_o   (dead_w),
      .blank_o  (blank_w),
      .pos_o    (pos_w),
      .on_win_o (on_win_w),
      .last_o   (last_w),
      .phase_o  (phase_w)
   );

   bpwm_term #(.CNT_W(CNT_W)) u_term (
      .clk      (clk),
      .rst_n    (rst_n),
      .on_win_i (on_win_w),
      .last_i   (last_w),
      .pos_i    (pos_w),
      .blank_i  (blank_w),
      .duty_i   (duty_i),
      .ilim_i   (ilim_i),
      .ocur_i   (ocur_i),
      .drive_o  (drive_w)
   );

   bpwm_steer #(.NUM_OUT(NOUT)) u_steer (
      .clk      (clk),
      .rst_n    (rst_n),
      .drive_i  (drive_w),
      .alt_i    (alt_mode_i),
      .phase_i  (phase_w),
      .out_o    (outs_w)
   );

   assign out_a_o = outs_w[0];
   assign out_b_o = outs_w[1];

endmodule

// File: rtl/bpwm_gen_chk.sv
`timescale 1ns/1ps
module bpwm_gen_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alt,
   input logic             ocur,
   input logic [CNT_W-1:0] duty,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] dead,
   input logic             on_win,
   input logic             last,
   input logic             drive,
   input logic             out_a,
   input logic             out_b
);

   p_dead_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt < dead) |=> (!out_a && !out_b))
      else $error("dead-time slot produced a pulse");

   p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (duty == '0) |=> (!out_a && !out_b))
      else $error("zero duty produced a pulse");

   p_ocur_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ocur |=> (!out_a && !out_b))
      else $error("overcurrent did not end the pulse");

   p_no_revive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (on_win && !last && !drive) |=> !drive)
      else $error("pulse resumed within a period");

   p_inphase_eq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !alt |=> (out_a == out_b))
      else $error("in-phase outputs differ");

   p_alt_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      alt |=> !(out_a && out_b))
      else $error("alternating outputs overlap");

endmodule

bind bpwm_gen bpwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .alt    (alt_mode_i),
   .ocur   (ocur_i),
   .duty   (duty_i),
   .cnt    (cnt_w),
   .dead   (dead_w),
   .on_win (on_win_w),
   .last   (last_w),
   .drive  (drive_w),
   .out_a  (out_a_o),
   .out_b  (out_b_o)
);

// File: tb/bpwm_gen_bench.sv
`timescale 1ns/1ps
module bpwm_gen_bench;
   localparam int W = 8;
   localparam int NONE = 99;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] period_i = '0, dead_i = '0, blank_i = '0, duty_i = '0;
   logic         ilim_i = 1'b0, ocur_i = 1'b0, alt_mode_i = 1'b0;
   logic         out_a_o, out_b_o;

   int total = 0;
   int bad = 0;
   int per_idx = 0;

   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   bpwm_gen #(.CNT_W(W)) u_bpwm_gen (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .dead_i(dead_i),
      .blank_i(blank_i), .duty_i(duty_i), .ilim_i(ilim_i), .ocur_i(ocur_i),
      .alt_mode_i(alt_mode_i), .out_a_o(out_a_o), .out_b_o(out_b_o)
   );

   // expected pulse width from the requirements (R3..R7)
   function automatic int exp_width(input int d, input int li, input int oc,
                                    input int b, input int l);
      int w;
      w = (d == 0) ? 0 : ((d > b) ? d : b);
      if (li >= b && li < w) w = li;
      if (oc < w) w = oc;
      if (w > l) w = l;
      return w;
   endfunction

   // monitor: one registered slot per clock
   always @(posedge clk) begin
      logic [1:0] e;
      string      t;
      #2;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         total++;
         if (out_a_o !== e[0] || out_b_o !== e[1]) begin
            bad++;
            $display("FAIL %s: a=%0b b=%0b expected a=%0b b=%0b",
                     t, out_a_o, out_b_o, e[0], e[1]);
         end
      end
   end

   task automatic apply_reset(input int p, input int d, input int b);
      rst_n = 1'b0;
      period_i = W'(p); dead_i = W'(d); blank_i = W'(b);
      duty_i = '0; ilim_i = 1'b0; ocur_i = 1'b0;
      repeat (3) @(negedge clk);
      total++;
      if (out_a_o !== 1'b0 || out_b_o !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset: a=%0b b=%0b expected a=0 b=0", out_a_o, out_b_o);
      end
      rst_n = 1'b1;
      per_idx = 0;
   endtask

   // driver: one period, p/d/b are the clamped values the design should use
   task automatic run_period(input int p, input int d, input int b, input int duty,
                             input int li, input int oc, input bit alt, input string tag);
      int  w;
      int  ph;
      bit  hi;
      w  = exp_width(duty, li, oc, b, p - d);
      ph = per_idx % 2;
      for (int s = 0; s < p; s++) begin
         duty_i     = W'(duty);
         ilim_i     = (s >= d) && ((s - d) == li);
         ocur_i     = (s >= d) && ((s - d) == oc);
         alt_mode_i = alt;
         hi = (s >= d) && ((s - d) < w);
         exp_q.push_back({hi && (!alt || ph == 1), hi && (!alt || ph == 0)});
         tag_q.push_back(tag);
         @(negedge clk);
      end
      per_idx++;
   endtask

   initial begin
      #(20 * 100000);
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // P=10 D=3 B=2, on window 7
      apply_reset(10, 3, 2);
      run_period(10, 3, 2, 4, NONE, NONE, 0, "R3 R9 duty 4");
      run_period(10, 3, 2, 0, NONE, NONE, 0, "R4 zero duty");
      run_period(10, 3, 2, 1, NONE, NONE, 0, "R5 duty under blank");
      run_period(10, 3, 2, 9, NONE, NONE, 0, "R2 R3 duty capped by dead time");
      run_period(10, 3, 2, 5, 1, NONE, 0, "R5 ilim masked in blank");
      run_period(10, 3, 2, 6, 3, NONE, 0, "R6 R8 ilim ends pulse");
      run_period(10, 3, 2, 5, NONE, 0, 0, "R7 ocur at pulse start");
      run_period(10, 3, 2, 5, NONE, 1, 0, "R7 ocur inside blank");
      run_period(10, 3, 2, 4, NONE, NONE, 1, "R10 alt even");
      run_period(10, 3, 2, 4, NONE, NONE, 1, "R10 alt odd");
      run_period(10, 3, 2, 6, NONE, NONE, 1, "R10 alt even wide");
      run_period(10, 3, 2, 5, 4, NONE, 1, "R10 R6 alt odd ilim");
      // new config applied mid-run: takes effect one period later
      period_i = W'(6); dead_i = W'(2); blank_i = W'(9);
      run_period(10, 3, 2, 3, NONE, NONE, 0, "R11 old config held");
      run_period(6, 2, 3, 1, NONE, NONE, 0, "R5 R11 blank clamped");
      run_period(6, 2, 3, 4, NONE, NONE, 0, "R3 full on window");
      run_period(6, 2, 3, 2, NONE, 3, 0, "R7 ocur after blank");
      // dead time of 0 clamps to 1
      apply_reset(5, 0, 0);
      run_period(5, 1, 0, 9, NONE, NONE, 1, "R1 R2 first period on A");
      run_period(5, 1, 0, 9, NONE, NONE, 1, "R2 R10 second period on B");
      run_period(5, 1, 0, 2, 0, NONE, 0, "R6 ilim unblanked at start");
      duty_i = '0;
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule